// File: doc/BRIEF.md
# Power and Reset Control Sequencer

This block turns one-byte commands written to a control register into timed reset sequences for a system-on-chip. The low nibble of the byte selects power-off and three kinds of reset: full reboot, normal reboot and memory-only reset. Bit 4 announces that sleep is about to be entered. The block drives three active-low reset lines: the main SoC reset, a secondary reset and a memory reset. It also emits single-cycle pulses that request power-off, announce sleep entry and clear the legacy-emulation register set.

A 1 ms tick input paces the sequence. Once a reset command is accepted, the selected resets are held for a fixed number of ticks and then released together. A second, longer interval follows. At its end a re-initialisation done strobe is issued. The block accepts no further command until that strobe. A mode input tells whether the system runs in legacy-emulation mode, and this decides whether a normal reboot also resets memory. The power-management IC link is not modelled: the main reset is driven directly.

Top module: `pwr_rst_seq`

## Requirements
- R1: After reset, soc_rst_n, aux_rst_n and mem_rst_n are 1, and legacy_clr, sleep_req, poweroff_req and reinit_done are 0.
- R2: An accepted write with bit 1 set (full reboot) drives soc_rst_n, aux_rst_n and mem_rst_n to 0 from the clock edge that samples the write.
- R3: An accepted write with bit 2 set (normal reboot) drives aux_rst_n to 0 and gives a one-cycle legacy_clr pulse. It also drives mem_rst_n to 0 only when legacy_mode is 1 in the write cycle.
- R4: An accepted write with only bit 3 set drives mem_rst_n to 0 and leaves soc_rst_n and aux_rst_n at 1.
- R5: When several of bits 1 to 3 are written together, each reset line that any of those bits selects is driven to 0.
- R6: An accepted write with bit 0 set gives a one-cycle poweroff_req pulse. If none of bits 1 to 3 is set, no reset line changes and no sequence starts, so the next write is accepted at once.
- R7: An accepted write with bit 4 set gives a one-cycle sleep_req pulse that clears itself. Bits 7 to 5 have no effect.
- R8: The asserted resets stay unchanged for HOLD_TICKS (default 5) ms_tick pulses. All of them return to 1 together on the edge that samples the last of those pulses.
- R9: reinit_done is a one-cycle pulse issued on the edge that samples the REINIT_TICKS-th (default 100) ms_tick pulse after the release, and not before.
- R10: While a sequence runs, from the accepted reset write until the reinit_done strobe, every write is ignored in full: no reset changes and no pulse on legacy_clr, sleep_req or poweroff_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| legacy_mode | input | 1 | 1 when the system runs in legacy-emulation mode |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control byte written |
| soc_rst_n | output | 1 | Main SoC reset, active low |
| aux_rst_n | output | 1 | Secondary reset, active low |
| mem_rst_n | output | 1 | Memory reset, active low |
| legacy_clr | output | 1 | One-cycle pulse clearing the legacy-emulation registers |
| sleep_req | output | 1 | One-cycle sleep-entry pulse |
| poweroff_req | output | 1 | One-cycle power-off request |
| reinit_done | output | 1 | One-cycle re-initialisation done strobe |

## Verification
If the sequencer's state goes wrong, a reset line shows it one clock after the write: a wrong decode or a missed mode qualifier produces a wrong pattern on the three reset lines right away. A tick counter that is off by one moves the release edge or the done strobe by one millisecond, so the bench samples after every single tick around both boundaries. A sequencer that drops back to idle too early lets a write made during the sequence show up on a reset line or a pulse output in the next cycle.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  localparam int CMD_W = 8;

  // bit positions inside the control byte
  localparam int B_OFF   = 0;
  localparam int B_FULL  = 1;
  localparam int B_NORM  = 2;
  localparam int B_MEM   = 3;
  localparam int B_SLEEP = 4;

  localparam logic [CMD_W-1:0] RST_FIELD_MASK = 8'h0F;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_HOLD = 2'd1,
    SEQ_WAIT = 2'd2
  } seq_state_e;

  // active-high reset set
  typedef struct packed {
    logic main_r;
    logic aux_r;
    logic mem_r;
  } rst_set_t;

  function automatic rst_set_t rst_set_of(input logic [CMD_W-1:0] cmd, input logic legacy);
    logic [CMD_W-1:0] f;
    rst_set_t s;
    f        = cmd & RST_FIELD_MASK;
    s.main_r = f[B_FULL];
    s.aux_r  = f[B_FULL] | f[B_NORM];
    s.mem_r  = f[B_FULL] | f[B_MEM] | (f[B_NORM] & legacy);
    return s;
  endfunction

  function automatic logic starts_seq(input logic [CMD_W-1:0] cmd);
    logic [CMD_W-1:0] f;
    f = cmd & RST_FIELD_MASK;
    return f[B_FULL] | f[B_NORM] | f[B_MEM];
  endfunction

endpackage

// File: rtl/pwr_cmd_decode.sv
module pwr_cmd_decode
  import pwr_seq_pkg::*;
(
  input  logic [CMD_W-1:0] cmd,
  input  logic             legacy,
  output rst_set_t         rst_set,
  output logic             start_seq,
  output logic             clr_legacy,
  output logic             pwr_off,
  output logic             sleep_ent
);
  logic [CMD_W-1:0] field;

  always_comb begin
    field      = cmd & RST_FIELD_MASK;
    rst_set    = rst_set_of(cmd, legacy);
    start_seq  = starts_seq(cmd);
    clr_legacy = field[B_NORM];
    pwr_off    = field[B_OFF];
    sleep_ent  = cmd[B_SLEEP];
  end
endmodule

// File: rtl/pwr_tick_timer.sv
module pwr_tick_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  always_comb begin
    last   = limit - CNT_W'(1);
    expire = tick && !clear && (cnt == last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (expire) cnt <= '0;
    else if (tick)   cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/pwr_rst_seq.sv
module pwr_rst_seq
  import pwr_seq_pkg::*;
#(
  parameter int HOLD_TICKS   = 5,
  parameter int REINIT_TICKS = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       legacy_mode,
  input  logic       ctrl_we,
  input  logic [7:0] ctrl_wdata,
  output logic       soc_rst_n,
  output logic       aux_rst_n,
  output logic       mem_rst_n,
  output logic       legacy_clr,
  output logic       sleep_req,
  output logic       poweroff_req,
  output logic       reinit_done
);
  localparam int MAX_TICKS = (HOLD_TICKS > REINIT_TICKS) ? HOLD_TICKS : REINIT_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  seq_state_e state;
  rst_set_t   rst_act;
  rst_set_t   dec_set;
  logic       dec_start, dec_clr, dec_off, dec_sleep;

  // named internal events
  logic             cmd_accept;
  logic             seq_start;
  logic             tmr_expire;
  logic             hold_expire;
  logic             wait_expire;
  logic [CNT_W-1:0] tmr_limit;
  logic             tmr_clear;

  pwr_cmd_decode u_dec (
    .cmd        (ctrl_wdata),
    .legacy     (legacy_mode),
    .rst_set    (dec_set),
    .start_seq  (dec_start),
    .clr_legacy (dec_clr),
    .pwr_off    (dec_off),
    .sleep_ent  (dec_sleep)
  );

  always_comb begin
    cmd_accept  = ctrl_we && (state == SEQ_IDLE);
    seq_start   = cmd_accept && dec_start;
    tmr_clear   = (state == SEQ_IDLE);
    tmr_limit   = (state == SEQ_HOLD) ? CNT_W'(HOLD_TICKS) : CNT_W'(REINIT_TICKS);
    hold_expire = (state == SEQ_HOLD) && tmr_expire;
    wait_expire = (state == SEQ_WAIT) && tmr_expire;
  end

  pwr_tick_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (tmr_clear),
    .tick   (ms_tick),
    .limit  (tmr_limit),
    .expire (tmr_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= SEQ_IDLE;
      rst_act      <= '0;
      legacy_clr   <= 1'b0;
      sleep_req    <= 1'b0;
      poweroff_req <= 1'b0;
      reinit_done  <= 1'b0;
    end else begin
      legacy_clr   <= cmd_accept && dec_clr;
      sleep_req    <= cmd_accept && dec_sleep;
      poweroff_req <= cmd_accept && dec_off;
      reinit_done  <= wait_expire;
      unique case (state)
        SEQ_IDLE: if (seq_start) begin
          state   <= SEQ_HOLD;
          rst_act <= dec_set;
        end
        SEQ_HOLD: if (hold_expire) begin
          state   <= SEQ_WAIT;
          rst_act <= '0;
        end
        SEQ_WAIT: if (wait_expire) state <= SEQ_IDLE;
        default:  state <= SEQ_IDLE;
      endcase
    end
  end

  assign soc_rst_n = ~rst_act.main_r;
  assign aux_rst_n = ~rst_act.aux_r;
  assign mem_rst_n = ~rst_act.mem_r;
endmodule

// File: rtl/pwr_rst_seq_chk.sv
module pwr_rst_seq_chk
  import pwr_seq_pkg::*;
#(
  parameter int HOLD_TICKS   = 5,
  parameter int REINIT_TICKS = 100
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ms_tick,
  input logic       ctrl_we,
  input logic [7:0] ctrl_wdata,
  input logic       soc_rst_n,
  input logic       aux_rst_n,
  input logic       mem_rst_n,
  input logic       legacy_clr,
  input logic       sleep_req,
  input logic       poweroff_req,
  input logic       reinit_done,
  input seq_state_e state,
  input logic       hold_expire
);
  int unsigned hold_seen;
  int unsigned wait_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_seen <= 0;
      wait_seen <= 0;
    end else begin
      hold_seen <= (state != SEQ_HOLD) ? 0 : hold_seen + (ms_tick ? 1 : 0);
      wait_seen <= (state != SEQ_WAIT) ? 0 : wait_seen + (ms_tick ? 1 : 0);
    end
  end

  a_r2_main_implies_all: assert property (@(posedge clk) disable iff (!rst_n)
    !soc_rst_n |-> (!aux_rst_n && !mem_rst_n));

  a_r3_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_clr |-> $past(ctrl_we && ctrl_wdata[B_NORM]));

  a_r6_off_single: assert property (@(posedge clk) disable iff (!rst_n)
    poweroff_req |=> !poweroff_req);

  a_r7_sleep_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> $past(ctrl_we && ctrl_wdata[B_SLEEP]));

  a_r8_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_IDLE) |-> (soc_rst_n && aux_rst_n && mem_rst_n));

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_HOLD && !hold_expire) |=> $stable({soc_rst_n, aux_rst_n, mem_rst_n}));

  a_r8_hold_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_HOLD) |-> (hold_seen < HOLD_TICKS));

  a_r9_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_WAIT) |-> (wait_seen < REINIT_TICKS));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    reinit_done |=> !reinit_done);

  a_r10_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state != SEQ_IDLE) |=> (!legacy_clr && !sleep_req && !poweroff_req));
endmodule

bind pwr_rst_seq pwr_rst_seq_chk #(
  .HOLD_TICKS   (HOLD_TICKS),
  .REINIT_TICKS (REINIT_TICKS)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ms_tick      (ms_tick),
  .ctrl_we      (ctrl_we),
  .ctrl_wdata   (ctrl_wdata),
  .soc_rst_n    (soc_rst_n),
  .aux_rst_n    (aux_rst_n),
  .mem_rst_n    (mem_rst_n),
  .legacy_clr   (legacy_clr),
  .sleep_req    (sleep_req),
  .poweroff_req (poweroff_req),
  .reinit_done  (reinit_done),
  .state        (state),
  .hold_expire  (hold_expire)
);

// File: tb/test_pwr_rst_seq.sv
module test_pwr_rst_seq;
  localparam int CLK_P  = 10;
  localparam int HOLD   = 5;
  localparam int REINIT = 100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic       legacy_mode = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = 8'h00;
  logic       soc_rst_n, aux_rst_n, mem_rst_n;
  logic       legacy_clr, sleep_req, poweroff_req, reinit_done;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  pwr_rst_seq #(.HOLD_TICKS(HOLD), .REINIT_TICKS(REINIT)) i_pwr_rst_seq (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .legacy_mode(legacy_mode),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .soc_rst_n(soc_rst_n), .aux_rst_n(aux_rst_n), .mem_rst_n(mem_rst_n),
    .legacy_clr(legacy_clr), .sleep_req(sleep_req), .poweroff_req(poweroff_req),
    .reinit_done(reinit_done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected {soc,aux,mem} levels, restated from the requirements
  function automatic logic [2:0] exp_lines(input logic [7:0] c, input logic leg);
    logic soc_lo, aux_lo, mem_lo;
    soc_lo = c[1];
    aux_lo = c[1] || c[2];
    mem_lo = c[1] || c[3] || (c[2] && leg);
    return {!soc_lo, !aux_lo, !mem_lo};
  endfunction

  function automatic logic [2:0] lines();
    return {soc_rst_n, aux_rst_n, mem_rst_n};
  endfunction

  function automatic logic [2:0] pulses();
    return {legacy_clr, sleep_req, poweroff_req};
  endfunction

  task automatic write_cmd(input logic [7:0] d);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = d;
    @(negedge clk); ctrl_we = 1'b0; ctrl_wdata = 8'h00;
  endtask

  task automatic one_tick();
    @(negedge clk); ms_tick = 1'b1;
    @(negedge clk); ms_tick = 1'b0;
  endtask

  // holds the given pattern for HOLD-1 ticks, releases on the last (R8)
  task automatic hold_and_release(input string req, input logic [2:0] pat);
    for (int i = 1; i < HOLD; i++) begin
      one_tick();
      check({req, " R8 held before last tick"}, lines(), pat);
    end
    one_tick();
    check({req, " R8 released on last tick"}, lines(), 3'b111);
  endtask

  task automatic reinit_wait(input string req);
    int early = 0;
    for (int i = 1; i < REINIT; i++) begin
      one_tick();
      if (reinit_done) early++;
    end
    check({req, " R9 no early done"}, early, 0);
    one_tick();
    check({req, " R9 done on last tick"}, reinit_done, 1'b1);
    @(negedge clk);
    check({req, " R9 done one cycle"}, reinit_done, 1'b0);
  endtask

  task automatic t_reset_state();
    check("R1 lines after reset", lines(), 3'b111);
    check("R1 pulses after reset", {pulses(), reinit_done}, 4'b0000);
  endtask

  task automatic t_full_reboot();
    legacy_mode = 1'b0;
    write_cmd(8'h02);
    check("R2 full reboot lines", lines(), 3'b000);
    check("R2 full reboot no clear", pulses(), 3'b000);
    hold_and_release("R2", 3'b000);
    reinit_wait("R2");
  endtask

  task automatic t_normal_reboot(input logic leg);
    legacy_mode = leg;
    write_cmd(8'h04);
    legacy_mode = 1'b0;
    check("R3 normal reboot lines", lines(), exp_lines(8'h04, leg));
    check("R3 legacy clear pulse", legacy_clr, 1'b1);
    @(negedge clk);
    check("R3 legacy clear one cycle", legacy_clr, 1'b0);
    hold_and_release("R3", exp_lines(8'h04, leg));
    reinit_wait("R3");
  endtask

  task automatic t_mem_only();
    legacy_mode = 1'b1;
    write_cmd(8'h08);
    check("R4 memory only lines", lines(), 3'b110);
    hold_and_release("R4", 3'b110);
    reinit_wait("R4");
  endtask

  task automatic t_union();
    legacy_mode = 1'b0;
    write_cmd(8'h0C);
    check("R5 union norm+mem", lines(), exp_lines(8'h0C, 1'b0));
    check("R5 union clear pulse", legacy_clr, 1'b1);
    hold_and_release("R5", exp_lines(8'h0C, 1'b0));
    reinit_wait("R5");
  endtask

  task automatic t_poweroff_sleep();
    write_cmd(8'h01);
    check("R6 poweroff pulse", pulses(), 3'b001);
    check("R6 no reset on poweroff", lines(), 3'b111);
    @(negedge clk);
    check("R6 poweroff one cycle", poweroff_req, 1'b0);
    write_cmd(8'h10);
    check("R7 sleep pulse accepted at once", pulses(), 3'b010);
    @(negedge clk);
    check("R7 sleep self-clears", sleep_req, 1'b0);
    write_cmd(8'hE0);
    check("R7 upper bits no pulse", pulses(), 3'b000);
    check("R7 upper bits no reset", lines(), 3'b111);
    one_tick();
    check("R7 upper bits no sequence", lines(), 3'b111);
  endtask

  task automatic t_busy_ignore();
    legacy_mode = 1'b0;
    write_cmd(8'h08);
    check("R10 seq started", lines(), 3'b110);
    write_cmd(8'h17);
    check("R10 hold write no reset change", lines(), 3'b110);
    check("R10 hold write no pulse", pulses(), 3'b000);
    hold_and_release("R10", 3'b110);
    write_cmd(8'h03);
    check("R10 wait write no reset", lines(), 3'b111);
    check("R10 wait write no pulse", pulses(), 3'b000);
    reinit_wait("R10");
    write_cmd(8'h01);
    check("R10 accepted after done", poweroff_req, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_full_reboot();
    t_normal_reboot(1'b0);
    t_normal_reboot(1'b1);
    t_mem_only();
    t_union();
    t_poweroff_sleep();
    t_busy_ignore();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule